// File: doc/BRIEF.md
# Variable-Length Bit-Field Unit

This block performs bit-field operations on a 64-bit window made of two adjacent 32-bit words. A field is given by a bit offset and a width of 1 to 32 bits. It may begin at any bit position and may straddle the boundary between the two words. Four operations are supported:

- zero-extending extract, which returns the field in a 32-bit result register;
- sign-extending extract, which does the same with the field's top bit copied upward;
- insert, which writes the low bits of a source value into the field and returns the modified window;
- test, which only evaluates the field.

Negative and zero flags describe the field as it stood before any insertion.

The surrounding datapath sets the operation inputs and pulses `start` for one cycle. On the next clock edge the unit loads its result, window and flag registers and raises `done` for that one cycle. All registered outputs hold their values until the next start.

Top module: `bitfield_unit`

## Requirements
- R1: The window is `{win_hi, win_lo}`. Offset 0 selects bit 63 (the MSB of `win_hi`), and the field runs from the selected bit toward the LSB for the given number of bits. Width code 0 means 32 bits, and codes 1 to 31 mean that many bits. Op encoding: 0 = unsigned extract, 1 = signed extract, 2 = insert, 3 = test.
- R2: Unsigned extract loads `result` with the field right-aligned and all higher bits zero.
- R3: Signed extract loads `result` with the field right-aligned and all higher bits equal to the field's top bit.
- R4: A field that crosses from `win_hi` into `win_lo` (bit 32 to bit 31) is handled like any other field.
- R5: The window is circular: a field that runs past bit 0 continues at bit 63, for both extract and insert.
- R6: Insert places bit k of `ins_val` (k < width) at field bit k, counted from the field's LSB. Every window bit outside the field is passed unchanged to `win_out_hi`/`win_out_lo`.
- R7: Extract and test load the window outputs with the unmodified input window. Insert and test leave `result` at its previous value.
- R8: For every op, `flag_n` equals the field's top bit and `flag_z` is 1 exactly when all field bits are 0, both taken from the field before insertion.
- R9: Outputs change only on the clock edge that samples `start` high. `done` is high for exactly the one cycle after each start and low otherwise.
- R10: While `rst_n` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation strobe |
| op | input | 2 | Operation code (see R1) |
| offset | input | 6 | Field start bit, counted from the window MSB |
| width_code | input | 5 | Field width, 0 meaning 32 |
| win_hi | input | 32 | Upper window word |
| win_lo | input | 32 | Lower window word |
| ins_val | input | 32 | Source value for insert |
| done | output | 1 | Completion pulse |
| result | output | 32 | Extracted field register |
| win_out_hi | output | 32 | Upper word of output window |
| win_out_lo | output | 32 | Lower word of output window |
| flag_n | output | 1 | Field top bit |
| flag_z | output | 1 | Field all-zero |

## Verification
Flag evaluation and window modification happen on the same edge for an insert, and the flags must reflect the old field rather than the inserted value. The bench provokes this by inserting a nonzero value into an all-zero field, and a zero value into a field whose top bit is set. It then checks that `flag_z` and `flag_n` describe the original contents while the window outputs already carry the new bits. A second overlap is a field that both wraps past bit 0 and straddles nothing else. The bench compares it against a bit-by-bit model that walks the window circularly.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int BF_WORD_W = 32;

  typedef enum logic [1:0] {
    BF_EXTU = 2'd0,
    BF_EXTS = 2'd1,
    BF_INS  = 2'd2,
    BF_TST  = 2'd3
  } bf_op_e;
endpackage

// File: rtl/bfu_rot.sv
// Logarithmic barrel rotator; LEFT selects the direction.
module bfu_rot #(
  parameter int W     = 64,
  parameter int AMT_W = 6,
  parameter bit LEFT  = 1'b1
) (
  input  logic [W-1:0]     din,
  input  logic [AMT_W-1:0] amt,
  output logic [W-1:0]     dout
);
  logic [W-1:0] stage [AMT_W+1];

  assign stage[0] = din;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    localparam int S = (1 << i) % W;
    logic [W-1:0] rotated;
    if (LEFT) begin : g_left
      assign rotated = (stage[i] << S) | (stage[i] >> (W - S));
    end else begin : g_right
      assign rotated = (stage[i] >> S) | (stage[i] << (W - S));
    end
    assign stage[i+1] = amt[i] ? rotated : stage[i];
  end

  assign dout = stage[AMT_W];
endmodule

// File: rtl/bfu_extract.sv
// Right-aligns a field held MSB-first in the top word and derives flags.
module bfu_extract #(
  parameter int WORD_W = 32,
  parameter int WID_W  = 5
) (
  input  logic [WORD_W-1:0] top,
  input  logic [WID_W:0]    fw,
  output logic [WORD_W-1:0] zext,
  output logic [WORD_W-1:0] sext,
  output logic              neg,
  output logic              zero
);
  logic [WID_W:0] shamt;

  always_comb begin
    shamt = WORD_W[WID_W:0] - fw;
    zext  = top >> shamt;
    sext  = WORD_W'($signed(top) >>> shamt);
    neg   = top[WORD_W-1];
    zero  = (zext == '0);
  end
endmodule

// File: rtl/bfu_merge.sv
// Builds the insert value and mask aligned at the top of the window.
module bfu_merge #(
  parameter int WORD_W = 32,
  parameter int WID_W  = 5
) (
  input  logic [WORD_W-1:0]   ins_val,
  input  logic [WID_W:0]      fw,
  output logic [2*WORD_W-1:0] val_top,
  output logic [2*WORD_W-1:0] mask_top
);
  logic [WID_W:0]    shamt;
  logic [WORD_W-1:0] mask_w;

  always_comb begin
    shamt    = WORD_W[WID_W:0] - fw;
    mask_w   = ~({WORD_W{1'b1}} >> fw);
    mask_top = {mask_w, {WORD_W{1'b0}}};
    val_top  = {(ins_val << shamt) & mask_w, {WORD_W{1'b0}}};
  end
endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit #(
  parameter int WORD_W = bfu_pkg::BF_WORD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 op,
  input  logic [$clog2(2*WORD_W)-1:0] offset,
  input  logic [$clog2(WORD_W)-1:0]  width_code,
  input  logic [WORD_W-1:0]          win_hi,
  input  logic [WORD_W-1:0]          win_lo,
  input  logic [WORD_W-1:0]          ins_val,
  output logic                       done,
  output logic [WORD_W-1:0]          result,
  output logic [WORD_W-1:0]          win_out_hi,
  output logic [WORD_W-1:0]          win_out_lo,
  output logic                       flag_n,
  output logic                       flag_z
);
  import bfu_pkg::*;

  localparam int WIN_W = 2 * WORD_W;
  localparam int OFF_W = $clog2(WIN_W);
  localparam int WID_W = $clog2(WORD_W);

  logic [WIN_W-1:0]  win_in;
  logic [WIN_W-1:0]  win_rot;
  logic [WID_W:0]    fw;
  logic [WORD_W-1:0] ex_zext, ex_sext;
  logic              ex_neg, ex_zero;
  logic [WIN_W-1:0]  val_top, mask_top, ins_vals, ins_mask, win_ins;
  bf_op_e            op_e;

  assign win_in = {win_hi, win_lo};
  assign fw     = (width_code == '0) ? WORD_W[WID_W:0] : {1'b0, width_code};
  assign op_e   = bf_op_e'(op);

  bfu_rot #(.W(WIN_W), .AMT_W(OFF_W), .LEFT(1'b1)) u_rot_win (
    .din(win_in), .amt(offset), .dout(win_rot)
  );

  bfu_extract #(.WORD_W(WORD_W), .WID_W(WID_W)) u_extract (
    .top(win_rot[WIN_W-1 -: WORD_W]), .fw(fw),
    .zext(ex_zext), .sext(ex_sext), .neg(ex_neg), .zero(ex_zero)
  );

  bfu_merge #(.WORD_W(WORD_W), .WID_W(WID_W)) u_merge (
    .ins_val(ins_val), .fw(fw), .val_top(val_top), .mask_top(mask_top)
  );

  bfu_rot #(.W(WIN_W), .AMT_W(OFF_W), .LEFT(1'b0)) u_rot_val (
    .din(val_top), .amt(offset), .dout(ins_vals)
  );

  bfu_rot #(.W(WIN_W), .AMT_W(OFF_W), .LEFT(1'b0)) u_rot_mask (
    .din(mask_top), .amt(offset), .dout(ins_mask)
  );

  assign win_ins = (win_in & ~ins_mask) | ins_vals;

  // Next-state logic
  logic              done_d, n_d, z_d;
  logic [WORD_W-1:0] res_d;
  logic [WIN_W-1:0]  wout_d;
  logic [WIN_W-1:0]  wout_q;

  always_comb begin
    done_d = start;
    res_d  = result;
    wout_d = wout_q;
    n_d    = flag_n;
    z_d    = flag_z;
    if (start) begin
      n_d    = ex_neg;
      z_d    = ex_zero;
      wout_d = win_in;
      unique case (op_e)
        BF_EXTU: res_d  = ex_zext;
        BF_EXTS: res_d  = ex_sext;
        BF_INS:  wout_d = win_ins;
        BF_TST:  res_d  = result;
        default: res_d  = result;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      wout_q <= '0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
    end else begin
      done   <= done_d;
      result <= res_d;
      wout_q <= wout_d;
      flag_n <= n_d;
      flag_z <= z_d;
    end
  end

  assign win_out_hi = wout_q[WIN_W-1 -: WORD_W];
  assign win_out_lo = wout_q[WORD_W-1:0];

  // Assertions
  assert_done_follows_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);
  assert_hold_without_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(result) && $stable(win_out_hi) && $stable(win_out_lo)));
  assert_zext_upper_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd0 && width_code != '0) |=> ((result >> $past(width_code)) == '0));
  assert_sign_matches_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd1) |=> (flag_n == result[WORD_W-1]));
  assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd0) |=> (flag_z == (result == '0)));
  assert_insert_keeps_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op == 2'd2) |=>
      ((({win_out_hi, win_out_lo} ^ $past(win_in)) & ~$past(ins_mask)) == '0));
  assert_insert_mask_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ($countones(ins_mask) == int'(fw)));
  assert_extract_window_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && op != 2'd2) |=> ({win_out_hi, win_out_lo} == $past(win_in)));
endmodule

// File: tb/bitfield_unit_bench.sv
module bitfield_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [1:0]  op;
  logic [5:0]  offset;
  logic [4:0]  width_code;
  logic [31:0] win_hi, win_lo, ins_val;
  logic        done, flag_n, flag_z;
  logic [31:0] result, win_out_hi, win_out_lo;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_res = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bitfield_unit u_bitfield_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .offset(offset),
    .width_code(width_code), .win_hi(win_hi), .win_lo(win_lo), .ins_val(ins_val),
    .done(done), .result(result), .win_out_hi(win_out_hi), .win_out_lo(win_out_lo),
    .flag_n(flag_n), .flag_z(flag_z)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int wpos(input int off, input int i);
    return (((63 - off - i) % 64) + 64) % 64;
  endfunction

  // Run one op and compare against a bit-walking model.
  task automatic run(input string req, input logic [1:0] o, input int off, input int wc,
                     input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] iv);
    logic [63:0] w, wnew;
    logic [31:0] fld, sx;
    int          wd;
    wd = (wc == 0) ? 32 : wc;
    w  = {hi, lo};
    wnew = w;
    fld = '0;
    for (int i = 0; i < wd; i++) begin
      fld[wd-1-i] = w[wpos(off, i)];
      wnew[wpos(off, i)] = iv[wd-1-i];
    end
    sx = fld;
    for (int k = wd; k < 32; k++) sx[k] = fld[wd-1];
    @(negedge clk);
    start = 1'b1; op = o; offset = 6'(off); width_code = 5'(wc);
    win_hi = hi; win_lo = lo; ins_val = iv;
    @(negedge clk);
    start = 1'b0;
    if (o == 2'd0) exp_res = fld;
    if (o == 2'd1) exp_res = sx;
    chk({req, " done"}, 64'(done), 64'd1);
    chk({req, " result"}, 64'(result), 64'(exp_res));
    chk({req, " window"}, {win_out_hi, win_out_lo}, (o == 2'd2) ? wnew : w);
    chk({req, " R8 flag_n"}, 64'(flag_n), 64'(fld[wd-1]));
    chk({req, " R8 flag_z"}, 64'(flag_z), 64'(fld == '0));
  endtask

  task automatic t_reset;
    chk("R10 reset outputs", {done, flag_n, flag_z, result[28:0], win_out_hi}, 64'd0);
    chk("R10 reset window lo", 64'(win_out_lo), 64'd0);
  endtask

  task automatic t_extract;
    run("R1 R2 top byte", 2'd0, 0, 8, 32'hA5_00_00_00, 32'h0, 32'h0);
    run("R2 mid field", 2'd0, 12, 7, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0);
    run("R1 R2 full width", 2'd0, 32, 0, 32'h0, 32'hDEAD_BEEF, 32'h0);
    run("R2 width one", 2'd0, 63, 1, 32'h0, 32'h1, 32'h0);
  endtask

  task automatic t_signed;
    run("R3 negative", 2'd1, 4, 5, 32'h0F00_0000, 32'h0, 32'h0);
    run("R3 positive", 2'd1, 8, 6, 32'h0070_0000, 32'h0, 32'h0);
    run("R3 full", 2'd1, 0, 0, 32'h8000_0001, 32'h0, 32'h0);
  endtask

  task automatic t_cross;
    run("R4 cross extract", 2'd0, 28, 8, 32'h0000_000B, 32'hC000_0000, 32'h0);
    run("R4 cross signed", 2'd1, 24, 16, 32'h0000_0080, 32'h1200_0000, 32'h0);
    run("R4 cross insert", 2'd2, 30, 4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5);
  endtask

  task automatic t_wrap;
    run("R5 wrap extract", 2'd0, 60, 8, 32'hF000_0000, 32'h0000_000F, 32'h0);
    run("R5 wrap insert", 2'd2, 62, 12, 32'h0, 32'h0, 32'hABC);
  endtask

  task automatic t_insert;
    run("R6 insert into zero R8", 2'd2, 16, 8, 32'h0, 32'h0, 32'hFFFF_FF5A);
    run("R6 insert zero over set R8", 2'd2, 0, 3, 32'hE000_0000, 32'h1, 32'h0);
    run("R6 insert full width", 2'd2, 32, 0, 32'h1111_1111, 32'h2222_2222, 32'hCAFE_F00D);
    run("R6 insert one bit", 2'd2, 40, 1, 32'h0, 32'h0, 32'h3);
  endtask

  task automatic t_keep;
    run("R7 extract sets", 2'd0, 0, 16, 32'h1357_0000, 32'h0, 32'h0);
    run("R7 insert holds result", 2'd2, 8, 8, 32'h0, 32'h0, 32'hFF);
    run("R7 test holds result", 2'd3, 0, 4, 32'hF000_0000, 32'h0, 32'h0);
  endtask

  task automatic t_timing;
    logic [63:0] w0;
    run("R9 setup", 2'd0, 4, 12, 32'h0ABC_0000, 32'h0, 32'h0);
    w0 = {win_out_hi, win_out_lo};
    @(negedge clk);
    op = 2'd2; win_hi = 32'hFFFF_FFFF; ins_val = 32'h0;
    @(negedge clk);
    chk("R9 done low after pulse", 64'(done), 64'd0);
    chk("R9 result held", 64'(result), 64'(exp_res));
    chk("R9 window held", {win_out_hi, win_out_lo}, w0);
  endtask

  task automatic t_random;
    for (int n = 0; n < 60; n++) begin
      run("R1 random", 2'($urandom_range(0, 3)), $urandom_range(0, 63),
          $urandom_range(0, 31), $urandom, $urandom, $urandom);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL R9 watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; op = '0; offset = '0; width_code = '0;
    win_hi = '0; win_lo = '0; ins_val = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_extract();
    t_signed();
    t_cross();
    t_wrap();
    t_insert();
    t_keep();
    t_timing();
    t_random();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule